// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger Interrupts

This block holds the outgoing and incoming byte queues that sit between a host register port and a serial byte engine. The host loads transmit bytes and unloads receive bytes through data registers; the engine takes transmit bytes and delivers receive bytes over a valid/ready handshake in each direction. Both queues have the same depth, set by a parameter. Depths of 16 and 64 entries are both supported, and the depth may be any value from 2 to 64.

Each queue has its own trigger level. The transmit side raises an almost-empty cause and the receive side raises an almost-full cause. A trailing timer flags receive bytes that stay below the receive trigger for too long. Writes into a full queue and reads from an empty queue are each reported separately. All causes, plus a transfer-event input from the engine, collect in one sticky status register that is cleared by writing ones. A per-bit enable register masks the status bits onto a single interrupt line.

Register byte offsets: 0x00 queue control, 0x04 trailing limit, 0x08 interrupt enable, 0x0C interrupt status, 0x10 queue status (read-only), 0x14 transmit data (write), 0x18 receive data (read, pops).

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset the interrupt status and enable registers read 0, `irq` is low, and queue status reads 0x0100_0100 (both queues empty, both levels 0).
- R2: Queue control bit 0 enables the receive queue, bit 1 enables the transmit queue, bits 10:4 hold the receive trigger and bits 22:16 the transmit trigger; the other bits read 0. A disabled queue is held empty and ignores pushes and pops without raising any cause, and `rx_ready` equals the receive enable.
- R3: Bytes written to 0x14 leave on `tx_data` in write order. `tx_valid` is high while the transmit queue is enabled and non-empty, and one byte is taken on each cycle with `tx_valid` and `tx_ready` high.
- R4: Bytes taken on `rx_valid` while `rx_ready` is high are returned in arrival order by reads of 0x18, and each read removes one byte.
- R5: Queue status holds the transmit level in bits 6:0, transmit full at bit 7, transmit empty at bit 8, the receive level in bits 22:16, receive full at bit 23 and receive empty at bit 24.
- R6: A host write to a full transmit queue is dropped and sets status bit 3. An engine push into a full receive queue is dropped and sets status bit 5, unless a host read pops the receive queue in the same cycle, in which case the push is kept and bit 5 is not set.
- R7: A host read of 0x18 with the receive queue empty returns 0 and sets status bit 4. `tx_ready` high with the transmit queue empty sets status bit 2 while `tx_valid` stays low.
- R8: Status bit 0 is set on every cycle in which the transmit queue is enabled and its level is at or below the transmit trigger. Status bit 1 is set on every cycle in which the receive queue is enabled and its level is at or above the receive trigger.
- R9: With trailing limit L (bits 3:0 of 0x04), status bit 6 is set at the (L+1)th clock edge after the last receive push or pop, provided the receive queue stays enabled, non-empty and below its trigger. It is not set at any earlier edge.
- R10: A one-cycle pulse on `xfer_evt` sets status bit 9.
- R11: Writing 0x0C clears exactly the status bits written as one. Bits written as zero are kept. A cause that sets a bit in the same cycle as its clear leaves that bit set.
- R12: `irq` is high exactly when some status bit is set and its enable bit at 0x08 (same bit position) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_addr | input | ADDR_W | Register byte offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops on 0x18) |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, combinational from the address |
| tx_valid | output | 1 | Transmit byte available to the engine |
| tx_data | output | 8 | Head transmit byte |
| tx_ready | input | 1 | Engine takes the transmit byte |
| rx_valid | input | 1 | Engine delivers a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive queue accepting |
| xfer_evt | input | 1 | Transfer event pulse from the engine |
| irq | output | 1 | Masked interrupt request |

## Verification
Two pairs of functions can land on the same edge. The first pair is a write-one-to-clear of the status register and a cause that sets the same bit. The bench raises a transmit underrun with `tx_ready` in the very cycle the host writes a one to bit 2, and expects the bit to read back as set. The second pair is an engine push and a host pop on a full receive queue. The bench drives both in one cycle and expects the popped byte to be the oldest, no overrun to be flagged, and the pushed byte to come out last after the queue drains.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;

  localparam int HOST_DW = 32;
  localparam int BYTE_W  = 8;
  localparam int LVL_FW  = 7;
  localparam int TRL_W   = 4;
  localparam int IRQ_W   = 10;

  // register byte offsets
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_TRAIL = 8'h04;
  localparam logic [7:0] OFS_IEN   = 8'h08;
  localparam logic [7:0] OFS_ISTAT = 8'h0C;
  localparam logic [7:0] OFS_QSTAT = 8'h10;
  localparam logic [7:0] OFS_TXD   = 8'h14;
  localparam logic [7:0] OFS_RXD   = 8'h18;

  // control field positions
  localparam int C_RX_EN    = 0;
  localparam int C_TX_EN    = 1;
  localparam int C_RXTRG_LO = 4;
  localparam int C_TXTRG_LO = 16;

  // queue status field positions
  localparam int S_TXLVL_LO = 0;
  localparam int S_TXFULL   = 7;
  localparam int S_TXEMPTY  = 8;
  localparam int S_RXLVL_LO = 16;
  localparam int S_RXFULL   = 23;
  localparam int S_RXEMPTY  = 24;

  // interrupt cause bit positions
  localparam int IB_TXAE  = 0;
  localparam int IB_RXAF  = 1;
  localparam int IB_TXUR  = 2;
  localparam int IB_TXOR  = 3;
  localparam int IB_RXUR  = 4;
  localparam int IB_RXOR  = 5;
  localparam int IB_TRAIL = 6;
  localparam int IB_XFER  = 9;

  localparam logic [IRQ_W-1:0] IRQ_MASK = 10'b10_0111_1111;

  typedef struct packed {
    logic [LVL_FW-1:0] tx_trig;
    logic [LVL_FW-1:0] rx_trig;
    logic              tx_en;
    logic              rx_en;
  } qctrl_t;

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             push,
  input  logic [7:0]       push_data,
  input  logic             pop,
  output logic [7:0]       pop_data,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             overrun,
  output logic             underrun
);

  logic [7:0]       mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [LVL_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == LVL_W'(DEPTH));
  assign do_pop   = enable & pop & ~empty;
  assign do_push  = enable & push & (~full | do_pop);
  assign overrun  = enable & push & full & ~do_pop;
  assign underrun = enable & pop & empty;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (!enable) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      if (do_push) wr_ptr_d = bump(wr_ptr_q);
      if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + LVL_W'(1);
        2'b01:   cnt_d = cnt_q - LVL_W'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  assign pop_data = empty ? 8'h00 : mem_q[rd_ptr_q];
  assign level    = cnt_q;

  // R6: level never exceeds the depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LVL_W'(DEPTH));

  // R6: a dropped push leaves the level untouched
  a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && full && push && !pop) |=> (cnt_q == $past(cnt_q)));

  // R7: a pop on an empty queue keeps it empty
  a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && empty && pop && !push) |=> empty);

  // R2: a disabled queue is flushed
  a_r2_disabled_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> empty);

endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             armed,
  input  logic [CNT_W-1:0] limit,
  output logic             fire
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_limit;

  assign at_limit = (cnt_q >= limit);
  assign fire     = armed & ~restart & at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !armed) cnt_d = '0;
    else if (!at_limit)    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: an idle or restarted timer starts again from zero
  a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !armed) |=> (cnt_q == '0));

  // R9: counting stays bounded by the limit while it is held
  a_r9_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !restart && cnt_q < limit) |=> (cnt_q <= $past(limit)));

endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] en,
  output logic [W-1:0] stat,
  output logic         irq
);

  logic [W-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = (stat_q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & en);

  // R11: a cause wins against a clear in the same cycle
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((stat_q & $past(set)) == $past(set)));

  // R11: cleared bits without a cause read zero
  a_r11_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((stat_q & $past(clr & ~set)) == '0));

  // R11: bits not written as one are kept
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R12: nothing enabled means no request
  a_r12_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  input  logic              xfer_evt,
  output logic              irq
);

  localparam int LVL_W = $clog2(DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  // address decode
  logic sel_ctrl, sel_trail, sel_ien, sel_istat, sel_qstat, sel_txd, sel_rxd;
  assign sel_ctrl  = (host_addr == OFS_CTRL[ADDR_W-1:0]);
  assign sel_trail = (host_addr == OFS_TRAIL[ADDR_W-1:0]);
  assign sel_ien   = (host_addr == OFS_IEN[ADDR_W-1:0]);
  assign sel_istat = (host_addr == OFS_ISTAT[ADDR_W-1:0]);
  assign sel_qstat = (host_addr == OFS_QSTAT[ADDR_W-1:0]);
  assign sel_txd   = (host_addr == OFS_TXD[ADDR_W-1:0]);
  assign sel_rxd   = (host_addr == OFS_RXD[ADDR_W-1:0]);

  // configuration registers
  qctrl_t           ctrl_q, ctrl_d;
  logic [TRL_W-1:0] trail_q, trail_d;
  logic [IRQ_W-1:0] ien_q, ien_d;
  logic             ctrl_we, trail_we, ien_we;

  assign ctrl_we  = host_wr & sel_ctrl;
  assign trail_we = host_wr & sel_trail;
  assign ien_we   = host_wr & sel_ien;

  always_comb begin
    ctrl_d  = ctrl_q;
    trail_d = trail_q;
    ien_d   = ien_q;
    if (ctrl_we) begin
      ctrl_d.rx_en   = host_wdata[C_RX_EN];
      ctrl_d.tx_en   = host_wdata[C_TX_EN];
      ctrl_d.rx_trig = host_wdata[C_RXTRG_LO +: LVL_FW];
      ctrl_d.tx_trig = host_wdata[C_TXTRG_LO +: LVL_FW];
    end
    if (trail_we) trail_d = host_wdata[TRL_W-1:0];
    if (ien_we)   ien_d   = host_wdata[IRQ_W-1:0] & IRQ_MASK;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ctrl_q  <= '0;
      trail_q <= '0;
      ien_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      trail_q <= trail_d;
      ien_q   <= ien_d;
    end
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^{host_wdata[31:23], host_wdata[15:11]};

  // transmit queue
  logic [LVL_W-1:0] tx_lvl;
  logic             tx_full, tx_empty, tx_ovr, tx_udr;

  byte_fifo #(.DEPTH(DEPTH)) u_txq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .enable   (ctrl_q.tx_en),
    .push     (host_wr & sel_txd),
    .push_data(host_wdata[7:0]),
    .pop      (tx_ready),
    .pop_data (tx_data),
    .level    (tx_lvl),
    .full     (tx_full),
    .empty    (tx_empty),
    .overrun  (tx_ovr),
    .underrun (tx_udr)
  );

  assign tx_valid = ctrl_q.tx_en & ~tx_empty;

  // receive queue
  logic [LVL_W-1:0] rx_lvl;
  logic [7:0]       rx_head;
  logic             rx_full, rx_empty, rx_ovr, rx_udr, rx_pop;

  assign rx_pop   = host_rd & sel_rxd;
  assign rx_ready = ctrl_q.rx_en;

  byte_fifo #(.DEPTH(DEPTH)) u_rxq (
    .clk      (clk),
    .rst_n    (rst_sn),
    .enable   (ctrl_q.rx_en),
    .push     (rx_valid),
    .push_data(rx_data),
    .pop      (rx_pop),
    .pop_data (rx_head),
    .level    (rx_lvl),
    .full     (rx_full),
    .empty    (rx_empty),
    .overrun  (rx_ovr),
    .underrun (rx_udr)
  );

  // level conditions
  logic [LVL_FW-1:0] tx_lvl_f, rx_lvl_f;
  logic              tx_ae, rx_af, trail_armed, trail_restart, trail_fire;

  assign tx_lvl_f = LVL_FW'(tx_lvl);
  assign rx_lvl_f = LVL_FW'(rx_lvl);
  assign tx_ae    = ctrl_q.tx_en & (tx_lvl_f <= ctrl_q.tx_trig);
  assign rx_af    = ctrl_q.rx_en & (rx_lvl_f >= ctrl_q.rx_trig);

  assign trail_armed   = ctrl_q.rx_en & ~rx_empty & (rx_lvl_f < ctrl_q.rx_trig);
  assign trail_restart = (rx_valid & ctrl_q.rx_en) | rx_pop;

  trail_timer #(.CNT_W(TRL_W)) u_trail (
    .clk    (clk),
    .rst_n  (rst_sn),
    .restart(trail_restart),
    .armed  (trail_armed),
    .limit  (trail_q),
    .fire   (trail_fire)
  );

  // interrupt causes
  logic [IRQ_W-1:0] cause, clr_vec, istat;

  always_comb begin
    cause           = '0;
    cause[IB_TXAE]  = tx_ae;
    cause[IB_RXAF]  = rx_af;
    cause[IB_TXUR]  = tx_udr;
    cause[IB_TXOR]  = tx_ovr;
    cause[IB_RXUR]  = rx_udr;
    cause[IB_RXOR]  = rx_ovr;
    cause[IB_TRAIL] = trail_fire;
    cause[IB_XFER]  = xfer_evt;
    clr_vec         = (host_wr & sel_istat) ? (host_wdata[IRQ_W-1:0] & IRQ_MASK) : '0;
  end

  irq_status_reg #(.W(IRQ_W)) u_irq (
    .clk  (clk),
    .rst_n(rst_sn),
    .set  (cause),
    .clr  (clr_vec),
    .en   (ien_q),
    .stat (istat),
    .irq  (irq)
  );

  // read mux
  logic [31:0] qstat_word;

  always_comb begin
    qstat_word                          = '0;
    qstat_word[S_TXLVL_LO +: LVL_FW]    = tx_lvl_f;
    qstat_word[S_TXFULL]                = tx_full;
    qstat_word[S_TXEMPTY]               = tx_empty;
    qstat_word[S_RXLVL_LO +: LVL_FW]    = rx_lvl_f;
    qstat_word[S_RXFULL]                = rx_full;
    qstat_word[S_RXEMPTY]               = rx_empty;
  end

  always_comb begin
    host_rdata = '0;
    if (sel_ctrl) begin
      host_rdata[C_RX_EN]                = ctrl_q.rx_en;
      host_rdata[C_TX_EN]                = ctrl_q.tx_en;
      host_rdata[C_RXTRG_LO +: LVL_FW]   = ctrl_q.rx_trig;
      host_rdata[C_TXTRG_LO +: LVL_FW]   = ctrl_q.tx_trig;
    end else if (sel_trail) begin
      host_rdata[TRL_W-1:0] = trail_q;
    end else if (sel_ien) begin
      host_rdata[IRQ_W-1:0] = ien_q;
    end else if (sel_istat) begin
      host_rdata[IRQ_W-1:0] = istat;
    end else if (sel_qstat) begin
      host_rdata = qstat_word;
    end else if (sel_rxd) begin
      host_rdata[7:0] = rx_head;
    end
  end

  // R3: an offered byte stays put until taken, unless the queue is reconfigured
  a_r3_tx_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    (tx_valid && !tx_ready && !ctrl_we) |=> (tx_valid && $stable(tx_data)));

  // R2: receive acceptance follows the enable
  a_r2_rx_ready: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctrl_q.rx_en |-> !rx_ready);

endmodule

// File: tb/i2c_fifo_pair_test.sv
module i2c_fifo_pair_test;

  localparam int DEPTH  = 64;
  localparam int ADDR_W = 5;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_TRL  = 5'h04;
  localparam logic [4:0] A_IEN  = 5'h08;
  localparam logic [4:0] A_IST  = 5'h0C;
  localparam logic [4:0] A_QST  = 5'h10;
  localparam logic [4:0] A_TXD  = 5'h14;
  localparam logic [4:0] A_RXD  = 5'h18;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] host_addr;
  logic              host_wr, host_rd;
  logic [31:0]       host_wdata, host_rdata;
  logic              tx_valid, tx_ready, rx_valid, rx_ready, xfer_evt, irq;
  logic [7:0]        tx_data, rx_data;

  int checks = 0;
  int errors = 0;

  i2c_fifo_pair #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .xfer_evt(xfer_evt), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic push_rx(input logic [7:0] b);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic clear_all();
    wr(A_IST, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(A_QST, d); chk("R1 R5 queue status after reset", d, 32'h0100_0100);
    peek(A_IST, d); chk("R1 status after reset", d, 32'h0);
    peek(A_IEN, d); chk("R1 enable after reset", d, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    wr(A_CTRL, 32'hFFFF_FFFF);
    peek(A_CTRL, d); chk("R2 control fields readback", d, 32'h007F_07F3);
    wr(A_CTRL, 32'h0);
    clear_all();
    wr(A_TXD, 32'h99);
    push_rx(8'h42);
    ticks(1);
    peek(A_QST, d); chk("R2 disabled queues stay empty", d, 32'h0100_0100);
    chk("R2 disabled tx_valid low", {31'b0, tx_valid}, 32'h0);
    chk("R2 disabled rx_ready low", {31'b0, rx_ready}, 32'h0);
    peek(A_IST, d); chk("R2 no cause from disabled queues", d, 32'h0);
  endtask

  task automatic t_tx_order();
    logic [31:0] d;
    logic [7:0]  exp_b [3];
    exp_b[0] = 8'hA1; exp_b[1] = 8'hB2; exp_b[2] = 8'hC3;
    wr(A_CTRL, 32'h2);
    for (int i = 0; i < 3; i++) wr(A_TXD, {24'h0, exp_b[i]});
    peek(A_QST, d); chk("R5 tx level 3", d, 32'h0100_0003);
    tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R3 tx_valid while bytes queued", {31'b0, tx_valid}, 32'h1);
      chk("R3 tx byte order", {24'h0, tx_data}, {24'h0, exp_b[i]});
      @(posedge clk); @(negedge clk);
    end
    tx_ready = 1'b0;
    #1 chk("R3 tx_valid low when drained", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_overrun();
    logic [31:0] d;
    int bad;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h2);
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(i));
    peek(A_QST, d);
    chk("R5 tx full status", d, 32'(DEPTH) | 32'h80 | 32'h0100_0000);
    clear_all();
    wr(A_TXD, 32'hEE);
    peek(A_IST, d); chk("R6 tx overrun bit 3", d & 32'h8, 32'h8);
    bad = 0;
    tx_ready = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1 if (tx_data !== 8'(i) || tx_valid !== 1'b1) bad++;
      @(posedge clk); @(negedge clk);
    end
    tx_ready = 1'b0;
    chk("R6 overrun byte dropped, rest intact", 32'(bad), 32'h0);
    #1 chk("R6 queue empty after drain", {31'b0, tx_valid}, 32'h0);
  endtask

  task automatic t_tx_underrun_w1c();
    logic [31:0] d;
    wr(A_CTRL, 32'h2);
    clear_all();
    tx_ready = 1'b1;
    #1 chk("R7 tx_valid low on empty", {31'b0, tx_valid}, 32'h0);
    @(posedge clk); @(negedge clk);
    tx_ready = 1'b0;
    peek(A_IST, d); chk("R7 tx underrun bit 2", d & 32'h4, 32'h4);
    wr(A_IST, 32'h8);
    peek(A_IST, d); chk("R11 zero bits kept", d & 32'h4, 32'h4);
    wr(A_IST, 32'h4);
    peek(A_IST, d); chk("R11 one bit cleared", d & 32'h4, 32'h0);
    // collision: underrun cause and clear of the same bit together
    host_addr = A_IST; host_wdata = 32'h4; host_wr = 1'b1; tx_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    host_wr = 1'b0; tx_ready = 1'b0;
    peek(A_IST, d); chk("R11 set wins over clear", d & 32'h4, 32'h4);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h7F1);
    #1 chk("R2 rx_ready follows enable", {31'b0, rx_ready}, 32'h1);
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33);
    peek(A_QST, d); chk("R5 rx level 3", d, 32'h0003_0100);
    rd(A_RXD, d); chk("R4 rx first", d, 32'h11);
    rd(A_RXD, d); chk("R4 rx second", d, 32'h22);
    rd(A_RXD, d); chk("R4 rx third", d, 32'h33);
    clear_all();
    rd(A_RXD, d); chk("R7 empty read returns zero", d, 32'h0);
    peek(A_IST, d); chk("R7 rx underrun bit 4", d & 32'h10, 32'h10);
  endtask

  task automatic t_rx_overrun();
    logic [31:0] d;
    int bad;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h7F1);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
    peek(A_QST, d);
    chk("R5 rx full status", d, (32'(DEPTH) << 16) | 32'h0080_0000 | 32'h100);
    clear_all();
    push_rx(8'h55);
    peek(A_IST, d); chk("R6 rx overrun bit 5", d & 32'h20, 32'h20);
    clear_all();
    // collision: push and pop together on a full queue
    host_addr = A_RXD; host_rd = 1'b1; rx_valid = 1'b1; rx_data = 8'h77;
    #1 d = host_rdata;
    @(posedge clk); @(negedge clk);
    host_rd = 1'b0; rx_valid = 1'b0;
    chk("R6 pop at full returns oldest", d, 32'h0);
    peek(A_IST, d); chk("R6 no overrun with same-cycle pop", d & 32'h20, 32'h0);
    bad = 0;
    for (int i = 1; i < DEPTH; i++) begin
      rd(A_RXD, d);
      if (d !== 32'(i)) bad++;
    end
    chk("R4 rx drain order", 32'(bad), 32'h0);
    rd(A_RXD, d); chk("R6 same-cycle push kept last", d, 32'h77);
  endtask

  task automatic t_triggers();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h0002_0002);
    for (int i = 0; i < 3; i++) wr(A_TXD, 32'h10 + 32'(i));
    clear_all();
    ticks(1);
    peek(A_IST, d); chk("R8 tx above trigger, bit 0 clear", d & 32'h1, 32'h0);
    tx_ready = 1'b1; @(posedge clk); @(negedge clk); tx_ready = 1'b0;
    ticks(1);
    peek(A_IST, d); chk("R8 tx at trigger, bit 0 set", d & 32'h1, 32'h1);
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h21);
    push_rx(8'hA0);
    clear_all();
    ticks(1);
    peek(A_IST, d); chk("R8 rx below trigger, bit 1 clear", d & 32'h2, 32'h0);
    push_rx(8'hA1);
    ticks(1);
    peek(A_IST, d); chk("R8 rx at trigger, bit 1 set", d & 32'h2, 32'h2);
  endtask

  task automatic t_trailing();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h81);
    wr(A_TRL, 32'h5);
    clear_all();
    push_rx(8'h3C);
    ticks(5);
    peek(A_IST, d); chk("R9 trailing not before limit+1 edges", d & 32'h40, 32'h0);
    ticks(1);
    peek(A_IST, d); chk("R9 trailing at limit+1 edges", d & 32'h40, 32'h40);
    peek(A_TRL, d); chk("R9 trailing limit readback", d, 32'h5);
  endtask

  task automatic t_xfer_irq();
    logic [31:0] d;
    wr(A_CTRL, 32'h0);
    wr(A_IEN, 32'h0);
    clear_all();
    xfer_evt = 1'b1; @(posedge clk); @(negedge clk); xfer_evt = 1'b0;
    peek(A_IST, d); chk("R10 transfer event bit 9", d, 32'h200);
    chk("R12 irq low with enables clear", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    #1 chk("R12 irq low with other bit enabled", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h200);
    #1 chk("R12 irq high with bit 9 enabled", {31'b0, irq}, 32'h1);
    wr(A_IST, 32'h200);
    #1 chk("R12 irq low after clear", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0; host_addr = '0; host_wr = 1'b0; host_rd = 1'b0; host_wdata = '0;
    tx_ready = 1'b0; rx_valid = 1'b0; rx_data = '0; xfer_evt = 1'b0;
    ticks(3);
    rst_n = 1'b1;
    ticks(4);
    t_reset();
    t_disabled();
    t_tx_order();
    t_tx_overrun();
    t_tx_underrun_w1c();
    t_rx();
    t_rx_overrun();
    t_triggers();
    t_trailing();
    t_xfer_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired, run hung (R1 to R12 incomplete)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule